// File: doc/BRIEF.md
# Floating-Point to Integer Converter with Selectable Overflow Policy

This block takes a 64-bit IEEE-754 double from a floating-point register and produces an integer for a general-purpose register. The integer is 32 or 64 bits wide and signed or unsigned. Any fractional part is dropped, so rounding is toward zero. A two-bit policy input decides what happens to NaN, to the infinities and to finite values that fall outside the target range. There are two clamping policies and one wrap policy that keeps the low bits of the exact truncated integer.

The caller presents the operand, the target width, the signedness and the policy, together with a one-cycle strobe. The integer appears one clock later with its own strobe. While no strobe is present, the last result stays on the output. A 32-bit result always fills the whole 64-bit output port: it is sign-extended for signed targets and zero-extended for unsigned ones.

Top module: `fp2int_conv`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` was high. In a cycle after `in_valid` was low, `out_valid` is low and `out_result` keeps its previous value. After reset, both outputs are 0.
- R2: In range, the result is the operand truncated toward zero. Magnitudes below 1, subnormals and both zeros give 0.
- R3: With a clamping policy (`in_mode` 0 or 1) and a signed target of W bits, a truncated value above 2^(W-1)-1 gives 2^(W-1)-1. A truncated value below -2^(W-1) gives -2^(W-1). +Inf and -Inf clamp the same way.
- R4: With a clamping policy and an unsigned target of W bits, any negative operand gives 0. An operand of 2^W or more, including +Inf, gives 2^W-1.
- R5: With `in_mode` 0, a NaN gives the smallest value of the target: -2^(W-1) for signed targets and 0 for unsigned ones.
- R6: With `in_mode` 1, a NaN gives 0.
- R7: With `in_mode` 2 or 3, a finite operand gives the low W bits of its exact truncated value, negated modulo 2^W when the operand is negative. This holds at any exponent. The result is 0 once every set bit of the value lies at or above bit W.
- R8: With `in_mode` 2 or 3, NaN and both infinities give 0.
- R9: When `in_wide` is 0 (W=32), bits 63:32 of `out_result` copy bit 31 for signed targets and are 0 for unsigned targets. When `in_wide` is 1, W is 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 64 | Double-precision source bits |
| in_wide | input | 1 | 1: 64-bit target, 0: 32-bit target |
| in_signed | input | 1 | 1: signed target, 0: unsigned |
| in_mode | input | 2 | 0 clamp/NaN-to-min, 1 clamp/NaN-to-zero, 2 or 3 wrap |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Integer result |

## Verification
The sweep walks the unbiased exponent from below zero to well past 64. It uses four significand patterns: all zeros, all ones, top and bottom bits only, and alternating bits. Both signs are applied at every width, signedness and policy. This separates the truncating shift-right region from the shift-left region and from the region where every bit falls off the end. The low-bit patterns show whether wrap mode keeps the exact bits or a clamped value. A list of edge operands covers the rest: ±0, a subnormal, ±2^31 and ±2^63 with their neighbours, 2^64, the largest finite value, the infinities and quiet and signalling NaNs. These tell apart the off-by-one limits at the signed minimum, the treatment of each policy's specials, and the upper-half extension of 32-bit results.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;

    localparam int FP_EXP_W  = 11;
    localparam int FP_FRAC_W = 52;
    localparam int FP_W      = 1 + FP_EXP_W + FP_FRAC_W;
    localparam int FP_BIAS   = (1 << (FP_EXP_W - 1)) - 1;
    localparam int UEXP_W    = FP_EXP_W + 2;

    typedef enum logic [1:0] {
        POL_CLAMP_MIN  = 2'd0,
        POL_CLAMP_ZERO = 2'd1,
        POL_WRAP       = 2'd2,
        POL_WRAP_ALT   = 2'd3
    } fp2int_pol_e;

    typedef struct packed {
        logic sign;
        logic nan;
        logic inf;
    } fp_class_t;

endpackage

// File: rtl/fp2int_unpack.sv
module fp2int_unpack
    import fp2int_pkg::*;
(
    input  logic [FP_W-1:0]          operand,
    output fp_class_t                cls,
    output logic signed [UEXP_W-1:0] exp_unb,
    output logic [FP_FRAC_W:0]       signif
);

    logic [FP_EXP_W-1:0]  exp_field;
    logic [FP_FRAC_W-1:0] frac_field;
    logic                 exp_max;

    assign exp_field  = operand[FP_W-2 -: FP_EXP_W];
    assign frac_field = operand[FP_FRAC_W-1:0];
    assign exp_max    = &exp_field;

    always_comb begin
        cls.sign = operand[FP_W-1];
        cls.nan  = exp_max && (|frac_field);
        cls.inf  = exp_max && !(|frac_field);
        exp_unb  = $signed({2'b00, exp_field}) - UEXP_W'(FP_BIAS);
        signif   = {|exp_field, frac_field};
    end

endmodule

// File: rtl/fp2int_align.sv
module fp2int_align
    import fp2int_pkg::*;
#(
    parameter int INT_W = 64
) (
    input  logic signed [UEXP_W-1:0] exp_unb,
    input  logic [FP_FRAC_W:0]       signif,
    output logic [INT_W-1:0]         mag_low
);

    int e_i;
    assign e_i = int'(exp_unb);

    always_comb begin
        mag_low = '0;
        if (e_i >= 0) begin
            if (e_i <= FP_FRAC_W) begin
                mag_low = INT_W'(signif >> (FP_FRAC_W - e_i));
            end else if ((e_i - FP_FRAC_W) < INT_W) begin
                mag_low = INT_W'(signif) << (e_i - FP_FRAC_W);
            end
        end
    end

endmodule

// File: rtl/fp2int_policy.sv
module fp2int_policy
    import fp2int_pkg::*;
#(
    parameter int INT_W    = 64,
    parameter int NARROW_W = 32
) (
    input  fp_class_t                cls,
    input  logic signed [UEXP_W-1:0] exp_unb,
    input  logic [INT_W-1:0]         mag_low,
    input  logic                     wide,
    input  logic                     sgn,
    input  fp2int_pol_e              pol,
    output logic [INT_W-1:0]         result
);

    localparam int NUM_W = 2;

    int e_i;
    logic [INT_W-1:0]            signed_val;
    logic [NUM_W-1:0][INT_W-1:0] res_w;

    assign e_i        = int'(exp_unb);
    assign signed_val = cls.sign ? (~mag_low + INT_W'(1)) : mag_low;

    for (genvar g = 0; g < NUM_W; g++) begin : g_width
        localparam int WD = (g == 0) ? NARROW_W : INT_W;

        logic [INT_W-1:0] umax_v, smax_v, smin_v, ext_v, r_v;
        logic             pos_ovf, neg_ovf, uns_ovf;

        always_comb begin
            umax_v  = (INT_W'(1) << WD) - INT_W'(1);
            smax_v  = (INT_W'(1) << (WD - 1)) - INT_W'(1);
            smin_v  = ~smax_v;
            ext_v   = signed_val & umax_v;
            if (sgn && signed_val[WD-1]) begin
                ext_v = ext_v | ~umax_v;
            end
            pos_ovf = cls.inf || (e_i >= WD - 1);
            neg_ovf = cls.inf || (e_i > WD - 1)
                   || ((e_i == WD - 1) && |(mag_low & smax_v));
            uns_ovf = cls.inf || (e_i >= WD);

            if (pol == POL_WRAP || pol == POL_WRAP_ALT) begin
                r_v = (cls.nan || cls.inf) ? '0 : ext_v;
            end else if (cls.nan) begin
                r_v = (pol == POL_CLAMP_MIN && sgn) ? smin_v : '0;
            end else if (sgn) begin
                if (!cls.sign && pos_ovf) begin
                    r_v = smax_v;
                end else if (cls.sign && neg_ovf) begin
                    r_v = smin_v;
                end else begin
                    r_v = ext_v;
                end
            end else begin
                if (cls.sign) begin
                    r_v = '0;
                end else if (uns_ovf) begin
                    r_v = umax_v;
                end else begin
                    r_v = mag_low;
                end
            end
        end

        assign res_w[g] = r_v;
    end

    assign result = wide ? res_w[1] : res_w[0];

endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
    import fp2int_pkg::*;
#(
    parameter int INT_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [FP_W-1:0]      in_operand,
    input  logic                 in_wide,
    input  logic                 in_signed,
    input  logic [1:0]           in_mode,
    output logic                 out_valid,
    output logic [INT_W-1:0]     out_result
);

    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] res;
    } stage_t;

    stage_t stage_d, stage_q;

    fp_class_t                cls;
    logic signed [UEXP_W-1:0] exp_unb;
    logic [FP_FRAC_W:0]       signif;
    logic [INT_W-1:0]         mag_low;
    logic [INT_W-1:0]         conv_res;
    fp2int_pol_e              pol;

    assign pol = fp2int_pol_e'(in_mode);

    fp2int_unpack u_unpack (
        .operand (in_operand),
        .cls     (cls),
        .exp_unb (exp_unb),
        .signif  (signif)
    );

    fp2int_align #(.INT_W(INT_W)) u_align (
        .exp_unb (exp_unb),
        .signif  (signif),
        .mag_low (mag_low)
    );

    fp2int_policy #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_policy (
        .cls     (cls),
        .exp_unb (exp_unb),
        .mag_low (mag_low),
        .wide    (in_wide),
        .sgn     (in_signed),
        .pol     (pol),
        .result  (conv_res)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.res = conv_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid  = stage_q.vld;
    assign out_result = stage_q.res;

endmodule

// File: rtl/fp2int_conv_chk.sv
module fp2int_conv_chk
    import fp2int_pkg::*;
#(
    parameter int INT_W    = 64,
    parameter int NARROW_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [FP_W-1:0]  in_operand,
    input logic             in_wide,
    input logic             in_signed,
    input logic [1:0]       in_mode,
    input logic             out_valid,
    input logic [INT_W-1:0] out_result
);

    logic op_special, op_nan, op_neg;
    assign op_special = &in_operand[FP_W-2 -: FP_EXP_W];
    assign op_nan     = op_special && (|in_operand[FP_FRAC_W-1:0]);
    assign op_neg     = in_operand[FP_W-1];

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result)));

    a_r4_unsigned_negative_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode[1] && !in_signed && op_neg && !op_nan)
        |=> (out_result == '0));

    a_r5_nan_signed_wide_min: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_nan && in_mode == 2'd0 && in_signed && in_wide)
        |=> (out_result == {1'b1, {(INT_W-1){1'b0}}}));

    a_r6_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_nan && in_mode == 2'd1) |=> (out_result == '0));

    a_r8_wrap_special_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_special && in_mode[1]) |=> (out_result == '0));

    a_r9_narrow_unsigned_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && !in_signed)
        |=> (out_result[INT_W-1:NARROW_W] == '0));

    a_r9_narrow_signed_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide && in_signed)
        |=> (out_result[INT_W-1:NARROW_W] == {(INT_W-NARROW_W){out_result[NARROW_W-1]}}));

endmodule

bind fp2int_conv fp2int_conv_chk #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_operand (in_operand),
    .in_wide    (in_wide),
    .in_signed  (in_signed),
    .in_mode    (in_mode),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/fp2int_conv_tb.sv
module fp2int_conv_tb_top;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic        in_wide = 1'b0;
    logic        in_signed = 1'b0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_NS/2) clk = ~clk;

    fp2int_conv dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_operand (in_operand),
        .in_wide    (in_wide),
        .in_signed  (in_signed),
        .in_mode    (in_mode),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic real pow2(input int n);
        real r = 1.0;
        for (int i = 0; i < n; i++) r = r * 2.0;
        return r;
    endfunction

    function automatic logic [63:0] extend(input logic [63:0] v, input int w, input bit sgn);
        if (w == 64) return v;
        return sgn ? {{32{v[31]}}, v[31:0]} : {32'b0, v[31:0]};
    endfunction

    function automatic logic [63:0] model(input logic [63:0] op, input bit wide,
                                          input bit sgn, input logic [1:0] mode,
                                          output string tag);
        int          w    = wide ? 64 : 32;
        int          bexp = int'(op[62:52]);
        bit          spec = (bexp == 2047);
        bit          nan  = spec && (op[51:0] != 0);
        bit          inf  = spec && (op[51:0] == 0);
        bit          neg  = op[63];
        logic [63:0] low  = '0;
        logic [63:0] v;
        logic [63:0] smax = (64'd1 << (w - 1)) - 64'd1;
        logic [63:0] umax = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        real         ax;
        for (int i = 0; i <= 52; i++) begin
            bit b   = (i == 52) ? (bexp != 0) : op[i];
            int pos = bexp - 1023 - 52 + i;
            if (b && pos >= 0 && pos < 64) low = low | (64'd1 << pos);
        end
        v = neg ? (64'd0 - low) : low;
        if (mode[1]) begin
            if (spec) begin tag = "R8"; return 64'd0; end
            tag = (w == 32) ? "R7 R9" : "R7";
            return extend(v, w, sgn);
        end
        if (nan) begin
            if (mode == 2'd0) begin tag = "R5"; return sgn ? extend(~smax, w, 1'b1) : 64'd0; end
            tag = "R6"; return 64'd0;
        end
        ax = inf ? pow2(70) : $bitstoreal({1'b0, op[62:0]});
        if (!sgn) begin
            if (neg) begin tag = "R4"; return 64'd0; end
            if (ax >= pow2(w)) begin tag = "R4"; return umax; end
            tag = (w == 32) ? "R2 R9" : "R2";
            return low;
        end
        if (!neg && ax >= pow2(w - 1)) begin tag = "R3"; return smax; end
        if (neg && ax >= pow2(w - 1) + 1.0) begin tag = "R3"; return extend(~smax, w, 1'b1); end
        tag = (w == 32) ? "R2 R9" : "R2";
        return extend(v, w, 1'b1);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v,
                         input logic [63:0] op);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%h actual=%h expected=%h", tag, op, act, exp_v);
        end
    endtask

    task automatic apply(input logic [63:0] op, input bit wide, input bit sgn,
                         input logic [1:0] mode);
        string       tag;
        logic [63:0] exp_v;
        @(negedge clk);
        in_valid   = 1'b1;
        in_operand = op;
        in_wide    = wide;
        in_signed  = sgn;
        in_mode    = mode;
        exp_v = model(op, wide, sgn, mode, tag);
        @(posedge clk);
        #1;
        check(tag, out_result, exp_v, op);
        check("R1 valid", {63'b0, out_valid}, 64'd1, op);
    endtask

    task automatic sweep_all(input logic [63:0] op);
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 4; c++)
                apply(op, c[1], c[0], m[1:0]);
    endtask

    logic [63:0] edge_ops [22] = '{
        64'h0000000000000000, 64'h8000000000000000, 64'h0000000000000001,
        64'h3FE0000000000000, 64'hBFE8000000000000, 64'h3FF8000000000000,
        64'hC00C000000000000, 64'h41DFFFFFFFC00000, 64'h41E0000000000000,
        64'hC1E0000000000000, 64'hC1E0000000100000, 64'hC1E0000000200000,
        64'h43E0000000000000, 64'hC3E0000000000000, 64'h43EFFFFFFFFFFFFF,
        64'h43F0000000000000, 64'h7FF0000000000000, 64'hFFF0000000000000,
        64'h7FF8000000000000, 64'hFFF0000000000001, 64'h7FEFFFFFFFFFFFFF,
        64'h4430000000000001
    };

    logic [51:0] fracs [4] = '{52'h0, 52'hFFFFFFFFFFFFF, 52'h8000000000001, 52'h5555555555555};

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", {63'b0, out_valid}, 64'd0, 64'd0);
        check("R1 reset result", out_result, 64'd0, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        foreach (edge_ops[k]) sweep_all(edge_ops[k]);

        for (int e = -3; e <= 72; e++)
            for (int f = 0; f < 4; f++)
                for (int s = 0; s < 2; s++)
                    sweep_all({s[0], 11'(1023 + e), fracs[f]});
        sweep_all({1'b0, 11'(2046), fracs[2]});

        // R1: idle cycle holds the result while the operand changes
        apply(64'h4059000000000000, 1'b1, 1'b1, 2'd0);
        held = out_result;
        @(negedge clk);
        in_valid   = 1'b0;
        in_operand = 64'hC0F0000000000000;
        @(posedge clk);
        #1;
        check("R1 idle valid", {63'b0, out_valid}, 64'd0, in_operand);
        check("R1 idle hold", out_result, held, in_operand);
        check("R1 idle value", out_result, 64'd100, in_operand);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule